// File: doc/BRIEF.md
# Matrix Keypad Scanner with Ready/Read Handshake

This block reads a matrix of push keys, by default four rows by four columns, and turns one pressed key into a binary location code. It enables one row driver at a time, and the pad drives an enabled row to 0. The other rows are released to high impedance. The columns have pull-ups and are read back through a synchronizer. When a key joins the enabled row to a column, that column reads 0 in that row's slot only.

A full scan visits every row once, in ascending order. At the end of each scan the block classifies the result in one of three ways: no key, exactly one key, or an unusable pattern. A key is accepted only after the same single key has been seen in a parameterised number of consecutive scans. On acceptance the block latches the code and raises a ready flag. The flag stays up until the consumer pulses a read input. A second key is reported only after the keypad has read fully open for the same number of consecutive scans.

Top module: `keypad_scan_ctrl`

## Requirements
- R1: While rst_n is low, row_oe_o is all 0, key_ready_o is 0 and key_code_o is 0.
- R2: At most one bit of row_oe_o is 1 at any time. A set bit means the pad drives that row to 0. A clear bit means the row floats.
- R3: After reset the enabled row steps through rows 0, 1, 2, 3 and then back to 0. Each row is enabled for exactly SLOT_CYCLES clock cycles.
- R4: The reported code is {row index, column index}, each 2 bits wide. A key on row r and column c, which pulls col_i[c] low while row_oe_o[r] is 1, gives code 4*r + c. For example, row 2 and column 1 give 4'h9.
- R5: key_ready_o rises only after the same single key has been seen in STABLE_SCANS consecutive scans. A press that lasts fewer scans is never reported.
- R6: Once key_ready_o is 1, it stays 1 and key_code_o holds steady until key_read_i is 1 on a clock edge. key_ready_o is 0 in the following cycle. A key that has already been debounced while the flag is up is reported after that read.
- R7: A scan is ignored if any slot shows two or more low columns, or if keys are seen on two different rows. Such a pattern is never reported.
- R8: After a key is accepted, no further key is reported until all columns have read 1 in STABLE_SCANS consecutive scans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_read_i | input | 1 | Consumer acknowledge; clears the ready flag |
| col_i | input | COLS | Column lines, pulled up, low when a key connects to the enabled row |
| row_oe_o | output | ROWS | Per-row drive enable; an enabled row is driven low |
| key_ready_o | output | 1 | A debounced key code is waiting |
| key_code_o | output | 4 | {row, column} location code of the accepted key |

## Verification
The assertions assume the following about the inputs:
- col_i settles to the keypad state within SLOT_CYCLES minus SYNC_STAGES cycles after a row enable changes.
- key_read_i is synchronous to clk.
- Reset is applied only through rst_n.

The bench models the keypad as a zero-delay resistive matrix. This model derives col_i directly from row_oe_o and a mask of pressed keys. All mask changes and read pulses are applied at falling clock edges, so every sample sees settled column levels.

// File: rtl/keyscan_pkg.sv
`timescale 1ns/1ps
package keyscan_pkg;

   // Result of one complete scan of the matrix
   typedef enum logic [1:0] {
      SCAN_NONE = 2'd0,   // every column high in every slot
      SCAN_KEY  = 2'd1,   // exactly one low column in exactly one slot
      SCAN_BAD  = 2'd2    // several columns or several rows hit
   } scan_kind_e;

   typedef enum logic {
      DB_WAIT_PRESS   = 1'b0,
      DB_WAIT_RELEASE = 1'b1
   } db_state_e;

endpackage

// File: rtl/keyscan_col_sync.sv
`timescale 1ns/1ps
module keyscan_col_sync #(
   parameter int COLS   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [COLS-1:0] col_raw_i,
   output logic [COLS-1:0] col_sync_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign col_sync_o = col_raw_i;
      end else begin : g_flops
         logic [COLS-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '1;   // released columns read high
               end else if (s == 0) begin
                  stage_q[s] <= col_raw_i;
               end else begin
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign col_sync_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/keyscan_sequencer.sv
`timescale 1ns/1ps
module keyscan_sequencer #(
   parameter int ROWS        = 4,
   parameter int SLOT_CYCLES = 16,
   localparam int ROW_W      = $clog2(ROWS),
   localparam int SLOT_W     = $clog2(SLOT_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [ROWS-1:0]  row_oe_o,
   output logic [ROW_W-1:0] row_idx_o,
   output logic             slot_end_o,
   output logic             scan_end_o
);

   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES-1);
   localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS-1);

   logic              run_q;
   logic [SLOT_W-1:0] slot_cnt_q;
   logic [ROW_W-1:0]  row_idx_q;
   logic              slot_end;

   // run_q keeps every row floating during the first cycle out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   assign slot_end = run_q && (slot_cnt_q == SLOT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt_q <= '0;
         row_idx_q  <= '0;
      end else if (run_q) begin
         if (slot_end) begin
            slot_cnt_q <= '0;
            row_idx_q  <= (row_idx_q == ROW_LAST) ? '0 : row_idx_q + 1'b1;
         end else begin
            slot_cnt_q <= slot_cnt_q + 1'b1;
         end
      end
   end

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row_en
         assign row_oe_o[r] = run_q && (row_idx_q == ROW_W'(r));
      end
   endgenerate

   assign row_idx_o  = row_idx_q;
   assign slot_end_o = slot_end;
   assign scan_end_o = slot_end && (row_idx_q == ROW_LAST);

endmodule

// File: rtl/keyscan_scan_eval.sv
`timescale 1ns/1ps
module keyscan_scan_eval
   import keyscan_pkg::*;
#(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int CODE_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_end_i,
   input  logic              scan_end_i,
   input  logic [ROW_W-1:0]  row_idx_i,
   input  logic [COLS-1:0]   col_i,
   output logic              res_valid_o,
   output scan_kind_e        res_kind_o,
   output logic [CODE_W-1:0] res_code_o
);

   localparam int NL_W = COL_W + 1;

   logic [COLS-1:0]   col_low;
   logic [NL_W-1:0]   n_low;
   logic [COL_W-1:0]  col_idx;
   logic              slot_hit, slot_multi;

   logic              acc_hit_q, acc_bad_q;
   logic [CODE_W-1:0] acc_code_q;
   logic              new_hit, new_bad;
   logic [CODE_W-1:0] new_code;

   assign col_low = ~col_i;

   always_comb begin
      n_low = '0;
      for (int c = 0; c < COLS; c++) begin
         n_low = n_low + NL_W'(col_low[c]);
      end
   end

   always_comb begin
      col_idx = '0;
      for (int c = COLS-1; c >= 0; c--) begin
         if (col_low[c]) col_idx = COL_W'(c);
      end
   end

   assign slot_hit   = (n_low == NL_W'(1));
   assign slot_multi = (n_low > NL_W'(1));

   // fold the current slot into the running scan summary
   assign new_bad  = acc_bad_q || slot_multi || (slot_hit && acc_hit_q);
   assign new_hit  = acc_hit_q || slot_hit;
   assign new_code = (slot_hit && !acc_hit_q) ? {row_idx_i, col_idx} : acc_code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hit_q   <= 1'b0;
         acc_bad_q   <= 1'b0;
         acc_code_q  <= '0;
         res_valid_o <= 1'b0;
         res_kind_o  <= SCAN_NONE;
         res_code_o  <= '0;
      end else begin
         res_valid_o <= 1'b0;
         if (slot_end_i) begin
            if (scan_end_i) begin
               res_valid_o <= 1'b1;
               res_code_o  <= new_code;
               res_kind_o  <= new_bad ? SCAN_BAD : (new_hit ? SCAN_KEY : SCAN_NONE);
               acc_hit_q   <= 1'b0;
               acc_bad_q   <= 1'b0;
               acc_code_q  <= '0;
            end else begin
               acc_hit_q   <= new_hit;
               acc_bad_q   <= new_bad;
               acc_code_q  <= new_code;
            end
         end
      end
   end

endmodule

// File: rtl/keyscan_debounce.sv
`timescale 1ns/1ps
module keyscan_debounce
   import keyscan_pkg::*;
#(
   parameter int CODE_W       = 4,
   parameter int STABLE_SCANS = 4,
   localparam int CNT_W       = $clog2(STABLE_SCANS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid_i,
   input  scan_kind_e        res_kind_i,
   input  logic [CODE_W-1:0] res_code_i,
   input  logic              key_read_i,
   output logic              key_ready_o,
   output logic [CODE_W-1:0] key_code_o
);

   localparam logic [CNT_W-1:0] CNT_GOAL = CNT_W'(STABLE_SCANS);

   db_state_e         state_q;
   logic [CODE_W-1:0] cand_q;
   logic [CNT_W-1:0]  match_q, match_nxt;
   logic [CNT_W-1:0]  rel_q;
   logic              accept;

   always_comb begin
      if (match_q != '0 && res_code_i == cand_q) begin
         match_nxt = (match_q == CNT_GOAL) ? match_q : match_q + 1'b1;
      end else begin
         match_nxt = CNT_W'(1);
      end
   end

   // an acceptance waits while an earlier code is still unread
   assign accept = res_valid_i && (state_q == DB_WAIT_PRESS) &&
                   (res_kind_i == SCAN_KEY) && (match_nxt == CNT_GOAL) && !key_ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= DB_WAIT_PRESS;
         cand_q      <= '0;
         match_q     <= '0;
         rel_q       <= '0;
         key_ready_o <= 1'b0;
         key_code_o  <= '0;
      end else begin
         if (key_read_i) key_ready_o <= 1'b0;
         if (res_valid_i) begin
            case (state_q)
               DB_WAIT_PRESS: begin
                  case (res_kind_i)
                     SCAN_KEY: begin
                        cand_q  <= res_code_i;
                        match_q <= match_nxt;
                        if (accept) begin
                           key_code_o  <= res_code_i;
                           key_ready_o <= 1'b1;
                           match_q     <= '0;
                           rel_q       <= '0;
                           state_q     <= DB_WAIT_RELEASE;
                        end
                     end
                     SCAN_NONE: match_q <= '0;
                     default:   ;   // unusable scan leaves the count alone
                  endcase
               end
               DB_WAIT_RELEASE: begin
                  case (res_kind_i)
                     SCAN_NONE: begin
                        if (rel_q + 1'b1 == CNT_GOAL) begin
                           rel_q   <= '0;
                           state_q <= DB_WAIT_PRESS;
                        end else begin
                           rel_q <= rel_q + 1'b1;
                        end
                     end
                     SCAN_KEY: rel_q <= '0;
                     default:  ;
                  endcase
               end
               default: state_q <= DB_WAIT_PRESS;
            endcase
         end
      end
   end

endmodule

// File: rtl/keypad_scan_ctrl.sv
`timescale 1ns/1ps
module keypad_scan_ctrl
   import keyscan_pkg::*;
#(
   parameter int ROWS         = 4,
   parameter int COLS         = 4,
   parameter int SLOT_CYCLES  = 2500,
   parameter int STABLE_SCANS = 4,
   parameter int SYNC_STAGES  = 2,
   localparam int ROW_W       = $clog2(ROWS),
   localparam int COL_W       = $clog2(COLS),
   localparam int CODE_W      = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_read_i,
   input  logic [COLS-1:0]   col_i,
   output logic [ROWS-1:0]   row_oe_o,
   output logic              key_ready_o,
   output logic [CODE_W-1:0] key_code_o
);

   generate
      if (ROWS < 2) begin : g_chk_rows
         $error("keypad_scan_ctrl: ROWS must be at least 2");
      end
      if (COLS < 2) begin : g_chk_cols
         $error("keypad_scan_ctrl: COLS must be at least 2");
      end
      if (SLOT_CYCLES < 2 || SLOT_CYCLES <= SYNC_STAGES) begin : g_chk_slot
         $error("keypad_scan_ctrl: SLOT_CYCLES must be at least 2 and exceed SYNC_STAGES");
      end
      if (STABLE_SCANS < 1) begin : g_chk_stable
         $error("keypad_scan_ctrl: STABLE_SCANS must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_chk_sync
         $error("keypad_scan_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [COLS-1:0]   col_s;
   logic [ROW_W-1:0]  row_idx;
   logic              slot_end, scan_end;
   logic              res_valid;
   scan_kind_e        res_kind;
   logic [CODE_W-1:0] res_code;

   keyscan_col_sync #(.COLS(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .col_raw_i  (col_i),
      .col_sync_o (col_s)
   );

   keyscan_sequencer #(.ROWS(ROWS), .SLOT_CYCLES(SLOT_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_oe_o   (row_oe_o),
      .row_idx_o  (row_idx),
      .slot_end_o (slot_end),
      .scan_end_o (scan_end)
   );

   keyscan_scan_eval #(.ROWS(ROWS), .COLS(COLS)) u_eval (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_end_i  (slot_end),
      .scan_end_i  (scan_end),
      .row_idx_i   (row_idx),
      .col_i       (col_s),
      .res_valid_o (res_valid),
      .res_kind_o  (res_kind),
      .res_code_o  (res_code)
   );

   keyscan_debounce #(.CODE_W(CODE_W), .STABLE_SCANS(STABLE_SCANS)) u_db (
      .clk         (clk),
      .rst_n       (rst_n),
      .res_valid_i (res_valid),
      .res_kind_i  (res_kind),
      .res_code_i  (res_code),
      .key_read_i  (key_read_i),
      .key_ready_o (key_ready_o),
      .key_code_o  (key_code_o)
   );

endmodule

// File: rtl/keypad_scan_ctrl_chk.sv
`timescale 1ns/1ps
module keypad_scan_ctrl_chk #(
   parameter int ROWS        = 4,
   parameter int SLOT_CYCLES = 16,
   parameter int CODE_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              key_read_i,
   input logic [ROWS-1:0]   row_oe_o,
   input logic              key_ready_o,
   input logic [CODE_W-1:0] key_code_o
);

   localparam int HW = $clog2(SLOT_CYCLES + 2) + 1;

   logic [ROWS-1:0] prev_oe;
   logic [HW-1:0]   hold_cnt;

   // cycles the previous enable pattern was held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_oe  <= '0;
         hold_cnt <= '0;
      end else begin
         prev_oe <= row_oe_o;
         if (row_oe_o != prev_oe)       hold_cnt <= HW'(1);
         else if (hold_cnt != '1)       hold_cnt <= hold_cnt + 1'b1;
      end
   end

   assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_oe_o));

   assert_row_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_oe_o != prev_oe && prev_oe != '0 && row_oe_o != '0)
         |-> (row_oe_o == {prev_oe[ROWS-2:0], prev_oe[ROWS-1]}));

   assert_slot_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_oe_o != prev_oe && prev_oe != '0 && row_oe_o != '0)
         |-> (hold_cnt == HW'(SLOT_CYCLES)));

   assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (key_ready_o && !key_read_i) |=> key_ready_o);

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (key_ready_o && key_read_i) |=> !key_ready_o);

   assert_code_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_ready_o |=> $stable(key_code_o));

endmodule

bind keypad_scan_ctrl keypad_scan_ctrl_chk #(
   .ROWS        (ROWS),
   .SLOT_CYCLES (SLOT_CYCLES),
   .CODE_W      (CODE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .key_read_i  (key_read_i),
   .row_oe_o    (row_oe_o),
   .key_ready_o (key_ready_o),
   .key_code_o  (key_code_o)
);

// File: tb/keypad_scan_ctrl_bench.sv
`timescale 1ns/1ps
module keypad_scan_ctrl_bench;

   localparam int SLOT  = 4;
   localparam int NSTAB = 4;
   localparam int SCAN  = 4 * SLOT;
   localparam int NVEC  = 11;

   // {pressed-key mask (bit 4*row+col), expect ready, expected code}
   localparam logic [20:0] VEC [NVEC] = '{
      {16'h0001, 1'b1, 4'h0},
      {16'h0200, 1'b1, 4'h9},
      {16'h8000, 1'b1, 4'hF},
      {16'h0010, 1'b1, 4'h4},
      {16'h0040, 1'b1, 4'h6},
      {16'h0008, 1'b1, 4'h3},
      {16'h1000, 1'b1, 4'hC},
      {16'h0003, 1'b0, 4'h0},
      {16'h0022, 1'b0, 4'h0},
      {16'h2004, 1'b0, 4'h0},
      {16'h0400, 1'b1, 4'hA}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_read = 1'b0;
   logic [15:0] pressed = '0;
   logic [3:0] col;
   logic [3:0] row_oe;
   logic       key_ready;
   logic [3:0] key_code;

   int n_chk = 0;
   int n_fail = 0;
   int multi_err = 0, order_err = 0, slot_err = 0;
   logic [3:0] mon_prev = '0;
   int mon_hold = 0;

   always #4 clk = ~clk;

   // resistive matrix: an enabled row pulls the columns of its pressed keys low
   always_comb begin
      col = '1;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (row_oe[r] && pressed[4*r+c]) col[c] = 1'b0;
   end

   keypad_scan_ctrl #(
      .SLOT_CYCLES  (SLOT),
      .STABLE_SCANS (NSTAB),
      .SYNC_STAGES  (2)
   ) u_keypad_scan_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .key_read_i  (key_read),
      .col_i       (col),
      .row_oe_o    (row_oe),
      .key_ready_o (key_ready),
      .key_code_o  (key_code)
   );

   // row sequence monitor for R2 and R3
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_prev = '0;
         mon_hold = 0;
      end else begin
         if ($countones(row_oe) > 1) multi_err++;
         if (row_oe != mon_prev) begin
            if (mon_prev != '0 && row_oe != '0) begin
               if (row_oe != {mon_prev[2:0], mon_prev[3]}) order_err++;
               if (mon_hold != SLOT) slot_err++;
            end
            mon_hold = 1;
            mon_prev = row_oe;
         end else begin
            mon_hold++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_pulse();
      @(negedge clk);
      key_read = 1'b1;
      @(negedge clk);
      key_read = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      cyc(100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      cyc(3);
      chk("R1 row_oe", row_oe, 0);
      chk("R1 ready", key_ready, 0);
      chk("R1 code", key_code, 0);
      rst_n = 1'b1;
      cyc(2);

      // R4 / R7 table walk
      for (int i = 0; i < NVEC; i++) begin
         pressed = VEC[i][20:5];
         cyc((NSTAB + 2) * SCAN);
         chk(VEC[i][4] ? "R4 ready" : "R7 ignored", key_ready, VEC[i][4]);
         if (VEC[i][4]) begin
            chk("R4 code", key_code, VEC[i][3:0]);
            read_pulse();
            chk("R6 cleared", key_ready, 0);
         end
         pressed = '0;
         cyc((NSTAB + 2) * SCAN);
      end

      // R5: not ready before NSTAB scans, ready afterwards
      pressed = 16'h0020;
      cyc((NSTAB - 1) * SCAN - 2);
      chk("R5 early", key_ready, 0);
      cyc(3 * SCAN);
      chk("R5 ready", key_ready, 1);
      chk("R5 code", key_code, 4'h5);
      read_pulse();
      pressed = '0;
      cyc((NSTAB + 2) * SCAN);

      // R5: short glitch press is dropped
      pressed = 16'h0080;
      cyc(2 * SCAN);
      pressed = '0;
      cyc(8 * SCAN);
      chk("R5 glitch", key_ready, 0);

      // R6: flag and code hold without a read, queued key after read
      pressed = 16'h0800;
      cyc((NSTAB + 2) * SCAN);
      chk("R6 ready", key_ready, 1);
      pressed = '0;
      cyc(10 * SCAN);
      chk("R6 hold", key_ready, 1);
      pressed = 16'h0004;
      cyc((NSTAB + 2) * SCAN);
      chk("R6 code held", key_code, 4'hB);
      chk("R6 still ready", key_ready, 1);
      read_pulse();
      chk("R6 read clears", key_ready, 0);
      cyc(2 * SCAN);
      chk("R6 queued ready", key_ready, 1);
      chk("R6 queued code", key_code, 4'h2);
      read_pulse();
      pressed = '0;
      cyc((NSTAB + 2) * SCAN);

      // R8: switching keys without a release is not reported
      pressed = 16'h0100;
      cyc((NSTAB + 2) * SCAN);
      chk("R8 first code", key_code, 4'h8);
      read_pulse();
      pressed = 16'h2000;
      cyc(8 * SCAN);
      chk("R8 no release", key_ready, 0);
      pressed = '0;
      cyc((NSTAB + 2) * SCAN);
      pressed = 16'h2000;
      cyc((NSTAB + 2) * SCAN);
      chk("R8 after release", key_ready, 1);
      chk("R8 code", key_code, 4'hD);

      // R2 / R3 from the row monitor
      chk("R2 one row", multi_err, 0);
      chk("R3 order", order_err, 0);
      chk("R3 slot length", slot_err, 0);

      // R1: reset while a key is pending
      rst_n = 1'b0;
      cyc(2);
      chk("R1 mid row_oe", row_oe, 0);
      chk("R1 mid ready", key_ready, 0);
      chk("R1 mid code", key_code, 0);

      finish_run();
   end

endmodule